// File: doc/BRIEF.md
# Priority Threshold Claim Arbiter

This block picks, for one interrupt target context, the source that should be presented next. Each source has three flags: a pending flag, an in-service flag that is set while a claim is outstanding, and a per-context enable flag. Each source also has a small priority value, and the context has a threshold. The block forms the set of eligible sources and keeps those whose priority lies strictly above the threshold. From what remains it returns the identifier of the highest-priority source. When two sources share the top priority, the lower identifier wins.

Identifier 0 is reserved and means that no source is selected. The block also drives a single interrupt request line for the context. By default the result is captured in a register once per clock, so the comparison tree stays off the bus read path. A parameter selects a purely combinational variant instead. Claim and complete side effects, register access and input gateways live in the surrounding controller.

Top module: `irq_claim_arbiter`

## Requirements
- R1: A source is eligible only when its pending bit is 1, its in-service bit is 0 and its enable bit is 1; clearing any one of these removes it from selection.
- R2: An eligible source can be selected only if its priority is strictly greater than the threshold; a priority equal to the threshold does not qualify.
- R3: Among qualifying sources sharing the highest priority, the one with the lowest identifier is selected.
- R4: The selected source has the highest priority of all qualifying sources.
- R5: Identifier 0 is reserved: the bit-0 inputs of the flag vectors have no effect, and the output identifier is 0 when no source qualifies.
- R6: The interrupt line `irq_o` is 1 exactly when `win_id_o` is nonzero.
- R7: A source with priority 0 is never selected, even with threshold 0.
- R8: In the default registered variant, `win_id_o` and `irq_o` reflect the inputs sampled at the previous rising clock edge (one cycle of latency).
- R9: While `rst` is 1, and until the first rising edge after it falls, `win_id_o` is 0 and `irq_o` is 0.

Source i uses bit i of each flag vector and bits [PRIO_W*i +: PRIO_W] of `prio_i`. The defaults are 32 identifiers (31 usable sources) and 3-bit priorities.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_SRC | Pending flag per source |
| busy_i | input | NUM_SRC | In-service (claimed) flag per source |
| en_i | input | NUM_SRC | Enable per source for this context |
| prio_i | input | NUM_SRC*PRIO_W | Packed priority per source |
| thresh_i | input | PRIO_W | Context threshold |
| win_id_o | output | $clog2(NUM_SRC) | Selected identifier, 0 if none |
| irq_o | output | 1 | Context interrupt request |

## Verification
The hardest case to produce from the ports is a tie at the top priority among three or more qualifying sources. In that case a lower-numbered source that is not eligible (in service, disabled, or at or below the threshold) must not take the tie, and a higher-numbered source must not displace the real lowest identifier. The directed vector table builds these cases explicitly, including ties at identifiers 1 and 31. Random vectors use a narrow priority range so that ties and equality with the threshold occur often, and each result is compared with a sequential scan model.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    localparam int unsigned DEF_NUM_SRC = 32;
    localparam int unsigned DEF_PRIO_W  = 3;

    // Output stage selection
    typedef enum logic {
        STAGE_COMB = 1'b0,
        STAGE_REG  = 1'b1
    } stage_e;

    // Number of tree levels needed to cover n leaves
    function automatic int unsigned tree_levels(input int unsigned n);
        int unsigned l;
        l = 0;
        while ((1 << l) < n) l++;
        return l;
    endfunction

endpackage

// File: rtl/irq_cand_mask.sv
module irq_cand_mask #(
    parameter int unsigned NUM_SRC = irq_sel_pkg::DEF_NUM_SRC
) (
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] busy_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic [NUM_SRC-1:0] cand_o
);
    // Identifier 0 is reserved and never becomes a candidate
    always_comb begin
        cand_o    = pend_i & ~busy_i & en_i;
        cand_o[0] = 1'b0;
    end
endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree #(
    parameter int unsigned NUM_SRC = irq_sel_pkg::DEF_NUM_SRC,
    parameter int unsigned PRIO_W  = irq_sel_pkg::DEF_PRIO_W,
    localparam int unsigned IW     = $clog2(NUM_SRC),
    localparam int unsigned LVL    = irq_sel_pkg::tree_levels(NUM_SRC),
    localparam int unsigned LEAVES = 1 << LVL
) (
    input  logic [NUM_SRC-1:0]        cand_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         thresh_i,
    output logic [IW-1:0]             id_o
);
    typedef struct packed {
        logic              vld;
        logic [PRIO_W-1:0] pr;
        logic [IW-1:0]     id;
    } node_t;

    for (genvar lv = 0; lv <= LVL; lv++) begin : g_lv
        node_t nd [LEAVES >> lv];
        if (lv == 0) begin : g_leaf
            for (genvar i = 0; i < LEAVES; i++) begin : g_i
                if (i < NUM_SRC) begin : g_real
                    assign nd[i].vld = cand_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > thresh_i);
                    assign nd[i].pr  = prio_i[i*PRIO_W +: PRIO_W];
                    assign nd[i].id  = IW'(i);
                end else begin : g_pad
                    assign nd[i] = '0;
                end
            end
        end else begin : g_node
            for (genvar k = 0; k < (LEAVES >> lv); k++) begin : g_k
                node_t lo, hi;
                assign lo = g_lv[lv-1].nd[2*k];
                assign hi = g_lv[lv-1].nd[2*k+1];
                // Upper half wins only on strictly higher priority: ties keep lower id
                assign nd[k] = (hi.vld && (!lo.vld || (hi.pr > lo.pr))) ? hi : lo;
            end
        end
    end

    assign id_o = g_lv[LVL].nd[0].vld ? g_lv[LVL].nd[0].id : '0;
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
    parameter int unsigned       IW    = 5,
    parameter irq_sel_pkg::stage_e STAGE = irq_sel_pkg::STAGE_REG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] id_i,
    output logic [IW-1:0] id_o,
    output logic          irq_o
);
    if (STAGE == irq_sel_pkg::STAGE_REG) begin : g_reg
        logic [IW-1:0] id_q;
        logic          irq_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                id_q  <= '0;
                irq_q <= 1'b0;
            end else begin
                id_q  <= id_i;
                irq_q <= |id_i;
            end
        end
        assign id_o  = id_q;
        assign irq_o = irq_q;
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst;
        assign id_o  = rst ? '0 : id_i;
        assign irq_o = !rst && (|id_i);
    end
endmodule

// File: rtl/irq_claim_arbiter.sv
module irq_claim_arbiter #(
    parameter int unsigned         NUM_SRC = irq_sel_pkg::DEF_NUM_SRC,
    parameter int unsigned         PRIO_W  = irq_sel_pkg::DEF_PRIO_W,
    parameter irq_sel_pkg::stage_e STAGE   = irq_sel_pkg::STAGE_REG,
    localparam int unsigned        IW      = $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SRC-1:0]        pend_i,
    input  logic [NUM_SRC-1:0]        busy_i,
    input  logic [NUM_SRC-1:0]        en_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         thresh_i,
    output logic [IW-1:0]             win_id_o,
    output logic                      irq_o
);
    logic [NUM_SRC-1:0] cand;
    logic [IW-1:0]      sel_id;

    irq_cand_mask #(.NUM_SRC(NUM_SRC)) u_mask (
        .pend_i (pend_i),
        .busy_i (busy_i),
        .en_i   (en_i),
        .cand_o (cand)
    );

    irq_prio_tree #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_tree (
        .cand_i   (cand),
        .prio_i   (prio_i),
        .thresh_i (thresh_i),
        .id_o     (sel_id)
    );

    irq_out_stage #(.IW(IW), .STAGE(STAGE)) u_out (
        .clk   (clk),
        .rst   (rst),
        .id_i  (sel_id),
        .id_o  (win_id_o),
        .irq_o (irq_o)
    );
endmodule

// File: rtl/irq_claim_arbiter_chk.sv
module irq_claim_arbiter_chk #(
    parameter int unsigned         NUM_SRC = irq_sel_pkg::DEF_NUM_SRC,
    parameter int unsigned         PRIO_W  = irq_sel_pkg::DEF_PRIO_W,
    parameter irq_sel_pkg::stage_e STAGE   = irq_sel_pkg::STAGE_REG,
    localparam int unsigned        IW      = $clog2(NUM_SRC)
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_SRC-1:0]        pend_i,
    input logic [NUM_SRC-1:0]        busy_i,
    input logic [NUM_SRC-1:0]        en_i,
    input logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input logic [PRIO_W-1:0]         thresh_i,
    input logic [IW-1:0]             win_id_o,
    input logic                      irq_o
);
    logic [NUM_SRC-1:0]        s_pend, s_busy, s_en;
    logic [NUM_SRC*PRIO_W-1:0] s_prio;
    logic [PRIO_W-1:0]         s_thr;
    logic                      s_vld;

    if (STAGE == irq_sel_pkg::STAGE_REG) begin : g_seen_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                s_vld <= 1'b0;
            end else begin
                s_vld <= 1'b1;
            end
            s_pend <= pend_i;
            s_busy <= busy_i;
            s_en   <= en_i;
            s_prio <= prio_i;
            s_thr  <= thresh_i;
        end
    end else begin : g_seen_comb
        assign s_vld  = 1'b1;
        assign s_pend = pend_i;
        assign s_busy = busy_i;
        assign s_en   = en_i;
        assign s_prio = prio_i;
        assign s_thr  = thresh_i;
    end

    logic [PRIO_W-1:0] w_prio;
    logic              w_elig;
    logic              better;
    always_comb begin
        w_prio = s_prio[win_id_o*PRIO_W +: PRIO_W];
        w_elig = s_pend[win_id_o] && !s_busy[win_id_o] && s_en[win_id_o];
        better = 1'b0;
        for (int j = 1; j < NUM_SRC; j++) begin
            if (s_pend[j] && !s_busy[j] && s_en[j] &&
                s_prio[j*PRIO_W +: PRIO_W] > s_thr) begin
                if (win_id_o == '0 ||
                    s_prio[j*PRIO_W +: PRIO_W] > w_prio ||
                    (s_prio[j*PRIO_W +: PRIO_W] == w_prio && IW'(j) < win_id_o))
                    better = 1'b1;
            end
        end
    end

    // R6
    p_irq_flag_r6: assert property (@(posedge clk) disable iff (rst)
        irq_o == (win_id_o != '0));
    // R1
    p_winner_elig_r1: assert property (@(posedge clk) disable iff (rst)
        (s_vld && win_id_o != '0) |-> w_elig);
    // R2
    p_above_thr_r2: assert property (@(posedge clk) disable iff (rst)
        (s_vld && win_id_o != '0) |-> (w_prio > s_thr));
    // R3, R4, R5: no qualifying source beats the winner, and 0 only when none qualifies
    p_no_better_r4: assert property (@(posedge clk) disable iff (rst)
        s_vld |-> !better);
    // R7
    p_prio_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (s_vld && win_id_o != '0) |-> (w_prio != '0));
endmodule

bind irq_claim_arbiter irq_claim_arbiter_chk #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .STAGE   (STAGE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pend_i   (pend_i),
    .busy_i   (busy_i),
    .en_i     (en_i),
    .prio_i   (prio_i),
    .thresh_i (thresh_i),
    .win_id_o (win_id_o),
    .irq_o    (irq_o)
);

// File: tb/irq_claim_arbiter_bench.sv
module irq_claim_arbiter_bench;
    localparam int N  = 32;
    localparam int PW = 3;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  pend = '0, busy = '0, en = '0;
    logic [N*PW-1:0] prio = '0;
    logic [PW-1:0] thr = '0;
    logic [IW-1:0] win_id;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_claim_arbiter u_irq_claim_arbiter (
        .clk(clk), .rst(rst), .pend_i(pend), .busy_i(busy), .en_i(en),
        .prio_i(prio), .thresh_i(thr), .win_id_o(win_id), .irq_o(irq)
    );

    typedef struct packed {
        logic [N-1:0]    pend;
        logic [N-1:0]    busy;
        logic [N-1:0]    en;
        logic [PW-1:0]   thr;
        logic [N*PW-1:0] prio;
        logic [IW-1:0]   exp;
        logic [7:0]      req;
    } vec_t;

    function automatic logic [N*PW-1:0] pset(input int idx, input int v);
        return (N*PW)'(v) << (PW*idx);
    endfunction

    function automatic logic [N-1:0] b(input int i);
        return N'(1) << i;
    endfunction

    localparam vec_t TBL [12] = '{
        '{b(3)|b(7), '0, b(3)|b(7), 3'd0, pset(3,5)|pset(7,5), 5'd3, 8'd3},
        '{b(3)|b(7), '0, b(3)|b(7), 3'd0, pset(3,5)|pset(7,6), 5'd7, 8'd4},
        '{b(3)|b(7), b(3), b(3)|b(7), 3'd0, pset(3,7)|pset(7,2), 5'd7, 8'd1},
        '{b(3)|b(7), '0, b(7), 3'd0, pset(3,7)|pset(7,1), 5'd7, 8'd1},
        '{b(3), '0, b(3)|b(7), 3'd0, pset(3,2)|pset(7,7), 5'd3, 8'd1},
        '{b(5), '0, b(5), 3'd4, pset(5,4), 5'd0, 8'd2},
        '{b(5), '0, b(5), 3'd4, pset(5,5), 5'd5, 8'd2},
        '{'1, '0, '1, 3'd0, '0, 5'd0, 8'd7},
        '{b(0), '0, b(0), 3'd0, pset(0,7), 5'd0, 8'd5},
        '{b(1)|b(31), '0, b(1)|b(31), 3'd6, pset(1,7)|pset(31,7), 5'd1, 8'd3},
        '{b(2)|b(9)|b(20), b(2), b(2)|b(9)|b(20), 3'd1, pset(2,6)|pset(9,6)|pset(20,6), 5'd9, 8'd3},
        '{'1, '0, '1, 3'd7, {(N*PW){1'b1}}, 5'd0, 8'd2}
    };

    function automatic logic [IW-1:0] ref_sel(input logic [N-1:0] p, input logic [N-1:0] c,
                                              input logic [N-1:0] e, input logic [N*PW-1:0] pr,
                                              input logic [PW-1:0] t);
        logic [PW-1:0] best;
        logic [IW-1:0] id;
        best = t;
        id   = '0;
        for (int j = 1; j < N; j++) begin
            if (p[j] && !c[j] && e[j] && pr[j*PW +: PW] > best) begin
                best = pr[j*PW +: PW];
                id   = IW'(j);
            end
        end
        return id;
    endfunction

    task automatic check_out(input logic [IW-1:0] exp, input string req);
        checks++;
        if (win_id !== exp) begin
            errors++;
            $display("FAIL %s id: actual %0d expected %0d", req, win_id, exp);
        end
        checks++;
        if (irq !== (exp != '0)) begin
            errors++;
            $display("FAIL R6 (%s) irq: actual %0b expected %0b", req, irq, exp != '0);
        end
    endtask

    task automatic drive(input vec_t v);
        pend = v.pend; busy = v.busy; en = v.en; thr = v.thr; prio = v.prio;
    endtask

    task automatic run_tests();
        vec_t v;
        // R9: reset holds outputs low despite a qualifying source
        pend = b(5); en = b(5); prio = pset(5,3); thr = '0;
        repeat (3) @(negedge clk);
        check_out('0, "R9");
        rst = 1'b0;
        #1 check_out('0, "R9");
        @(negedge clk);
        check_out(5'd5, "R8");

        // Table walk
        foreach (TBL[i]) begin
            @(negedge clk);
            drive(TBL[i]);
            @(negedge clk);
            check_out(TBL[i].exp, $sformatf("R%0d table %0d", TBL[i].req, i));
        end

        // R8: output holds until the next edge, then follows
        v = TBL[0];
        @(negedge clk); drive(v);
        @(negedge clk); check_out(5'd3, "R8");
        drive(TBL[1]);
        #1 check_out(5'd3, "R8");
        @(negedge clk); check_out(5'd7, "R8");

        // R5: bit-0 inputs have no effect on a live selection
        pend = b(0)|b(4); en = b(0)|b(4); prio = pset(0,7)|pset(4,2); thr = 3'd1; busy = '0;
        @(negedge clk); check_out(5'd4, "R5");

        // R9: reset asserted mid-run clears outputs
        rst = 1'b1;
        @(negedge clk); check_out('0, "R9");
        rst = 1'b0;
        @(negedge clk); check_out(5'd4, "R8");

        // Random against scan model, narrow priorities to force ties
        for (int k = 0; k < 400; k++) begin
            logic [IW-1:0] exp;
            pend = N'($urandom()); busy = N'($urandom()) & N'($urandom());
            en = N'($urandom()) | N'($urandom());
            for (int j = 0; j < N; j++)
                prio[j*PW +: PW] = (k % 2 == 0) ? PW'($urandom_range(0, 2)) + 3'd3
                                                : PW'($urandom());
            thr = PW'($urandom_range(0, 5));
            exp = ref_sel(pend, busy, en, prio, thr);
            @(negedge clk);
            check_out(exp, "R4 random");
        end
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule